// File: doc/BRIEF.md
# Receive Status Priority Encoder

This block sits at the edge of a receive path that delivers two symbols per clock on a 16-bit bus. For each lane it takes the symbol byte, its control (K) flag, a decode-error flag and a disparity-error flag. It also takes four per-cycle events from the elastic buffer: overflow, underflow, SKP symbol added and SKP symbol removed. From these it builds one shared 3-bit receive status code for the byte pair. Any byte that could not be decoded is replaced with the EDB control symbol.

Every output is registered, so the result appears one clock after the inputs. The status code belongs to that one cycle only and is never stretched. Errors are ranked by a fixed order, and every error ranks above the SKP adjustment codes. EDB replacement is decided separately for each lane. The status code describes both lanes together and does not say which lane caused it. When the input valid is low, all event flags are ignored.

The design has no sequential control: each cycle is evaluated on its own. It has three parts: a per-lane substitution stage, a combinational priority stage and the output register.

Top module: `rxst_merge`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `out_valid`, `out_k`, `out_data` and `out_status` are all zero.
- R2: Outputs follow inputs after exactly one clock. A valid cycle with no flags set passes the bytes and K flags unchanged, with status 000 and `out_valid` high. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R3: A decode error on a lane replaces only that lane's byte with 0xFE and sets its K flag. The other lane passes unchanged. The status is 100.
- R4: An overflow gives status 101 and leaves the data and K flags unchanged.
- R5: An underflow gives status 110 and drives both lanes as 0xFE with the K flag set.
- R6: A disparity error on either lane gives status 111 and leaves the data unchanged. Lane 0 and lane 1 produce the same code.
- R7: When several errors occur together, the status follows this ranking, highest first: decode error (100), overflow (101), underflow (110), disparity (111). A decode error on one lane therefore hides a disparity error on the other lane.
- R8: With no error, SKP added gives 001 and SKP removed gives 010. If both are set, 001 wins. Any error code takes precedence over either SKP code.
- R9: When `in_valid` is low, all flags are ignored. The output has status 000, `out_valid` low, and the bytes and K flags unchanged.
- R10: A status code lasts exactly one cycle. A clean valid cycle after an error cycle shows 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input cycle carries symbols |
| in_data | input | 16 | Two symbol bytes, lane 0 in bits 7:0 |
| in_k | input | 2 | Per-lane control flag |
| dec_err | input | 2 | Per-lane decode error |
| disp_err | input | 2 | Per-lane disparity error |
| ovf | input | 1 | Elastic buffer overflow this cycle |
| unf | input | 1 | Elastic buffer underflow this cycle |
| skp_add | input | 1 | SKP symbol inserted this cycle |
| skp_rem | input | 1 | SKP symbol dropped this cycle |
| out_valid | output | 1 | Registered valid |
| out_data | output | 16 | Registered, possibly substituted bytes |
| out_k | output | 2 | Registered K flags |
| out_status | output | 3 | Registered shared status code |

## Verification
The bench targets the points where the ranking is easy to get wrong. These are decode error against disparity on opposite lanes, overflow against underflow, underflow against disparity, and errors against SKP codes. A reversed or incomplete ranking shows up as the wrong code in exactly those cycles. Lane independence is tested by putting a decode error on each lane in turn. A design that substitutes the whole pair, or the wrong lane, corrupts the clean byte. Other tests cover underflow without a decode error, flags raised while valid is low, and a clean cycle right after an error. These catch a design that substitutes only one lane, acts on invalid cycles, or holds a status code for longer than one cycle.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

    // Shared receive status code values.
    typedef enum logic [2:0] {
        ST_NONE  = 3'b000,
        ST_SKPIN = 3'b001,
        ST_SKPOUT= 3'b010,
        ST_DECODE= 3'b100,
        ST_OVFL  = 3'b101,
        ST_UNFL  = 3'b110,
        ST_DISP  = 3'b111
    } rx_code_e;

    localparam logic [7:0] EDB_SYM = 8'hFE;

endpackage

// File: rtl/rxst_lane.sv
module rxst_lane #(
    parameter int BW = 8
) (
    input  logic          lane_valid,
    input  logic [BW-1:0] lane_data,
    input  logic          lane_k,
    input  logic          lane_dec,
    input  logic          pair_unf,
    output logic [BW-1:0] sub_data,
    output logic          sub_k
);
    import rxst_pkg::*;

    logic replace;

    // A lane is replaced when its own symbol failed to decode or the
    // buffer ran dry for the whole pair.
    always_comb begin
        replace = lane_valid && (lane_dec || pair_unf);
        if (replace) begin
            sub_data = BW'(EDB_SYM);
            sub_k    = 1'b1;
        end else begin
            sub_data = lane_data;
            sub_k    = lane_k;
        end
    end

endmodule

// File: rtl/rxst_prio.sv
module rxst_prio #(
    parameter int LANES = 2
) (
    input  logic             pr_valid,
    input  logic [LANES-1:0] pr_dec,
    input  logic [LANES-1:0] pr_disp,
    input  logic             pr_ovf,
    input  logic             pr_unf,
    input  logic             pr_skp_add,
    input  logic             pr_skp_rem,
    output rxst_pkg::rx_code_e pr_code
);
    import rxst_pkg::*;

    // Fixed ranking: decode, overflow, underflow, disparity, then SKP codes.
    always_comb begin
        pr_code = ST_NONE;
        if (!pr_valid)        pr_code = ST_NONE;
        else if (|pr_dec)     pr_code = ST_DECODE;
        else if (pr_ovf)      pr_code = ST_OVFL;
        else if (pr_unf)      pr_code = ST_UNFL;
        else if (|pr_disp)    pr_code = ST_DISP;
        else if (pr_skp_add)  pr_code = ST_SKPIN;
        else if (pr_skp_rem)  pr_code = ST_SKPOUT;
        else                  pr_code = ST_NONE;
    end

endmodule

// File: rtl/rxst_merge.sv
module rxst_merge #(
    parameter int LANES = 2,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [LANES*BW-1:0] in_data,
    input  logic [LANES-1:0]    in_k,
    input  logic [LANES-1:0]    dec_err,
    input  logic [LANES-1:0]    disp_err,
    input  logic                ovf,
    input  logic                unf,
    input  logic                skp_add,
    input  logic                skp_rem,
    output logic                out_valid,
    output logic [LANES*BW-1:0] out_data,
    output logic [LANES-1:0]    out_k,
    output logic [2:0]          out_status
);
    import rxst_pkg::*;

    localparam int DW = LANES * BW;

    logic [DW-1:0]    nxt_data;
    logic [LANES-1:0] nxt_k;
    rx_code_e         nxt_code;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxst_lane #(.BW(BW)) u_lane (
            .lane_valid (in_valid),
            .lane_data  (in_data[g*BW +: BW]),
            .lane_k     (in_k[g]),
            .lane_dec   (dec_err[g]),
            .pair_unf   (unf),
            .sub_data   (nxt_data[g*BW +: BW]),
            .sub_k      (nxt_k[g])
        );
    end

    rxst_prio #(.LANES(LANES)) u_prio (
        .pr_valid   (in_valid),
        .pr_dec     (dec_err),
        .pr_disp    (disp_err),
        .pr_ovf     (ovf),
        .pr_unf     (unf),
        .pr_skp_add (skp_add),
        .pr_skp_rem (skp_rem),
        .pr_code    (nxt_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_k      <= '0;
            out_status <= ST_NONE;
        end else begin
            out_valid  <= in_valid;
            out_data   <= nxt_data;
            out_k      <= nxt_k;
            out_status <= nxt_code;
        end
    end

endmodule

// File: rtl/rxst_merge_chk.sv
module rxst_merge_chk #(
    parameter int LANES = 2,
    parameter int BW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [LANES*BW-1:0] in_data,
    input logic [LANES-1:0]    dec_err,
    input logic                ovf,
    input logic                unf,
    input logic                out_valid,
    input logic [LANES*BW-1:0] out_data,
    input logic [LANES-1:0]    out_k,
    input logic [2:0]          out_status
);

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R7
    dec_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && |dec_err) |=> out_status == 3'b100);

    // R5
    unf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unf && !ovf && !(|dec_err)) |=>
            (out_status == 3'b110) && (&out_k));

    // R9
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_status == 3'b000) && (out_data == $past(in_data)));

    for (genvar g = 0; g < LANES; g++) begin : g_sub
        // R3
        edb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && dec_err[g]) |=>
                (out_data[g*BW +: BW] == BW'(8'hFE)) && out_k[g]);
    end

endmodule

bind rxst_merge rxst_merge_chk #(.LANES(LANES), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .dec_err    (dec_err),
    .ovf        (ovf),
    .unf        (unf),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_k      (out_k),
    .out_status (out_status)
);

// File: tb/sim_rxst_merge.sv
`timescale 1ns/1ps
module sim_rxst_merge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_k = '0;
    logic [1:0]  dec_err = '0;
    logic [1:0]  disp_err = '0;
    logic        ovf = 1'b0;
    logic        unf = 1'b0;
    logic        skp_add = 1'b0;
    logic        skp_rem = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic [1:0]  out_k;
    logic [2:0]  out_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxst_merge u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_k(in_k), .dec_err(dec_err), .disp_err(disp_err), .ovf(ovf),
        .unf(unf), .skp_add(skp_add), .skp_rem(skp_rem),
        .out_valid(out_valid), .out_data(out_data), .out_k(out_k),
        .out_status(out_status)
    );

    task automatic expect_out(input string req, input logic ev,
                              input logic [1:0] ek, input logic [15:0] ed,
                              input logic [2:0] es);
        n_chk++;
        if (out_valid !== ev || out_k !== ek || out_data !== ed || out_status !== es) begin
            n_bad++;
            $display("FAIL %s: got v=%b k=%b d=%h s=%b, expected v=%b k=%b d=%h s=%b",
                     req, out_valid, out_k, out_data, out_status, ev, ek, ed, es);
        end
    endtask

    // Drive one input cycle away from the edge, then sample after the next edge.
    task automatic step(input logic v, input logic [15:0] d, input logic [1:0] k,
                        input logic [1:0] de, input logic [1:0] di,
                        input logic o, input logic u, input logic sa, input logic sr);
        @(negedge clk);
        in_valid = v; in_data = d; in_k = k; dec_err = de; disp_err = di;
        ovf = o; unf = u; skp_add = sa; skp_rem = sr;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1, 16'hA5C3, 2'b11, 2'b01, 2'b00, 1, 0, 0, 0);
        expect_out("R1 in reset", 0, 2'b00, 16'h0000, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        in_valid = 0; in_data = 0; in_k = 0; dec_err = 0; ovf = 0;
        @(posedge clk); #1;
        expect_out("R1 after reset", 0, 2'b00, 16'h0000, 3'b000);
    endtask

    task automatic t_clean();
        step(1, 16'h1234, 2'b00, 0, 0, 0, 0, 0, 0);
        expect_out("R2 clean data", 1, 2'b00, 16'h1234, 3'b000);
        step(1, 16'hBC1C, 2'b11, 0, 0, 0, 0, 0, 0);
        expect_out("R2 clean K pair", 1, 2'b11, 16'hBC1C, 3'b000);
    endtask

    task automatic t_decode();
        step(1, 16'h5A3C, 2'b00, 2'b01, 2'b00, 0, 0, 0, 0);
        expect_out("R3 decode lane0", 1, 2'b01, 16'h5AFE, 3'b100);
        step(1, 16'h5A3C, 2'b01, 2'b10, 2'b01, 0, 0, 0, 0);
        expect_out("R3 R7 decode lane1 masks disparity lane0", 1, 2'b11, 16'hFE3C, 3'b100);
    endtask

    task automatic t_ovf_unf();
        step(1, 16'h7788, 2'b10, 0, 0, 1, 0, 0, 0);
        expect_out("R4 overflow", 1, 2'b10, 16'h7788, 3'b101);
        step(1, 16'h7788, 2'b00, 0, 0, 0, 1, 0, 0);
        expect_out("R5 underflow", 1, 2'b11, 16'hFEFE, 3'b110);
    endtask

    task automatic t_disp();
        step(1, 16'h4142, 2'b00, 0, 2'b10, 0, 0, 0, 0);
        expect_out("R6 disparity lane1", 1, 2'b00, 16'h4142, 3'b111);
        step(1, 16'h4344, 2'b00, 0, 2'b01, 0, 0, 0, 0);
        expect_out("R6 disparity lane0", 1, 2'b00, 16'h4344, 3'b111);
    endtask

    task automatic t_rank();
        step(1, 16'h0102, 2'b00, 2'b01, 0, 1, 0, 0, 0);
        expect_out("R7 decode over overflow", 1, 2'b01, 16'h01FE, 3'b100);
        step(1, 16'h0304, 2'b00, 0, 0, 1, 1, 0, 0);
        expect_out("R7 overflow over underflow", 1, 2'b11, 16'hFEFE, 3'b101);
        step(1, 16'h0506, 2'b00, 0, 2'b11, 0, 1, 0, 0);
        expect_out("R7 underflow over disparity", 1, 2'b11, 16'hFEFE, 3'b110);
    endtask

    task automatic t_skp();
        step(1, 16'h1CBC, 2'b11, 0, 0, 0, 0, 1, 0);
        expect_out("R8 skp add", 1, 2'b11, 16'h1CBC, 3'b001);
        step(1, 16'h1CBC, 2'b11, 0, 0, 0, 0, 0, 1);
        expect_out("R8 skp remove", 1, 2'b11, 16'h1CBC, 3'b010);
        step(1, 16'h1CBC, 2'b11, 0, 0, 0, 0, 1, 1);
        expect_out("R8 skp both", 1, 2'b11, 16'h1CBC, 3'b001);
        step(1, 16'h1CBC, 2'b11, 0, 2'b01, 0, 0, 1, 0);
        expect_out("R8 disparity over skp", 1, 2'b11, 16'h1CBC, 3'b111);
        step(1, 16'h1CBC, 2'b11, 0, 0, 1, 0, 0, 1);
        expect_out("R8 overflow over skp", 1, 2'b11, 16'h1CBC, 3'b101);
    endtask

    task automatic t_invalid();
        step(0, 16'h9ABC, 2'b01, 2'b11, 2'b11, 1, 1, 1, 1);
        expect_out("R9 flags ignored when invalid", 0, 2'b01, 16'h9ABC, 3'b000);
    endtask

    task automatic t_single();
        step(1, 16'h2233, 2'b00, 2'b10, 0, 0, 0, 0, 0);
        expect_out("R10 error cycle", 1, 2'b10, 16'hFE33, 3'b100);
        step(1, 16'h2233, 2'b00, 0, 0, 0, 0, 0, 0);
        expect_out("R10 next cycle clean", 1, 2'b00, 16'h2233, 3'b000);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_decode();
        t_ovf_unf();
        t_disp();
        t_rank();
        t_skp();
        t_invalid();
        t_single();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule